// File: doc/BRIEF.md
# Descending Round-Robin Bus Arbiter

This block decides which of several processor masters owns a shared bus. Each master raises its request line and keeps it up while it needs the bus. The arbiter grants exactly one requester at a time. The grant is held until the owner signals that it has released the bus. The grant is registered: the winner is picked at a clock edge when the bus is free, and its grant line rises after that edge.

Two policies can be selected with a mode input. In rotating mode the search walks downward through the master indices, starting at the top index after reset and wrapping from index 0 back to the top, so every persistent requester is served within one full rotation. In fixed mode the lowest-numbered requester always wins, which is cheaper to reason about but can starve high-numbered masters.

Top module: `bus_arbiter_desc`

## Requirements
- R1: During and just after reset, `grant` is all zero, `owner_idx` is 0, and the rotation pointer points at index N_MASTERS-1.
- R2: `grant` is one-hot or zero. While a grant is active, `owner_idx` holds the binary index of the granted bit. While no grant is active, `owner_idx` is 0.
- R3: In rotating mode, the first grant after reset goes to the highest-indexed requesting master. In a four-master system that is index 3 if index 3 is requesting.
- R4: In rotating mode, after master k is granted, the next search starts at index k-1 and walks downward. Masters that are not requesting are skipped within the same arbitration cycle.
- R5: In rotating mode, the search after master 0 is granted starts again at index N_MASTERS-1.
- R6: In fixed mode (`rr_mode`=0), the lowest-indexed requesting master wins. The rotation pointer is not changed by fixed-mode grants.
- R7: While the bus is owned, `grant` and `owner_idx` stay unchanged until `bus_release` is sampled high, whatever the other request lines do.
- R8: When `bus_release` is sampled high while the bus is owned, the grant is zero after that edge. A new winner is picked at the following edge.
- R9: When the bus is free and no request is high, no grant is issued and the rotation pointer is held.
- R10: `bus_release` sampled high while the bus is free has no effect.
- R11: In rotating mode, with all masters requesting continuously, the grants follow the order N-1, N-2, …, 0, N-1. Every requester is served within N grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 1 selects rotating descending order, 0 selects fixed lowest-index priority |
| req | input | N_MASTERS | One request line per master |
| bus_release | input | 1 | Current owner gives up the bus |
| grant | output | N_MASTERS | One-hot grant, zero when the bus is free |
| owner_idx | output | $clog2(N_MASTERS) | Index of the current owner, 0 when free |

## Verification
The properties assume that `bus_release` comes only from the current owner. They do not assume that requests stay up while a master owns the bus. For that reason stability is checked against the release line only, not against the owner's request line. The stimulus sweeps every request pattern in both modes, applies releases both while the bus is owned and while it is free, and changes other requests while a grant is held. A cycle model in the bench follows the same rules and predicts each grant.

// File: rtl/bus_arbiter_desc.sv
module bus_arbiter_desc #(
  parameter int N_MASTERS = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rr_mode,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 bus_release,
  output logic [N_MASTERS-1:0] grant,
  output logic [IW-1:0]        owner_idx
);

  localparam logic [IW-1:0] TOP = IW'(N_MASTERS - 1);

  logic          busy_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] ptr_q;
  logic          pick_ok;
  logic [IW-1:0] pick_idx;

  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    if (rr_mode) begin
      for (int k = 0; k < N_MASTERS; k++) begin
        if (!pick_ok && req[(int'(ptr_q) + N_MASTERS - k) % N_MASTERS]) begin
          pick_ok  = 1'b1;
          pick_idx = IW'((int'(ptr_q) + N_MASTERS - k) % N_MASTERS);
        end
      end
    end else begin
      for (int i = 0; i < N_MASTERS; i++) begin
        if (!pick_ok && req[i]) begin
          pick_ok  = 1'b1;
          pick_idx = IW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= TOP;
    end else if (busy_q) begin
      if (bus_release) busy_q <= 1'b0;
    end else if (pick_ok) begin
      busy_q  <= 1'b1;
      owner_q <= pick_idx;
      if (rr_mode) ptr_q <= (pick_idx == '0) ? TOP : pick_idx - 1'b1;
    end
  end

  assign grant     = busy_q ? (N_MASTERS'(1) << owner_q) : '0;
  assign owner_idx = busy_q ? owner_q : '0;

endmodule

// File: rtl/bus_arbiter_desc_checks.sv
module bus_arbiter_desc_checks #(
  parameter int N_MASTERS = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rr_mode,
  input logic [N_MASTERS-1:0] req,
  input logic                 bus_release,
  input logic [N_MASTERS-1:0] grant,
  input logic [IW-1:0]        owner_idx
);

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_index_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (grant == (N_MASTERS'(1) << owner_idx)));

  assert_idle_index_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (owner_idx == '0));

  assert_hold_until_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !bus_release) |=> ($stable(grant) && $stable(owner_idx)));

  assert_release_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && bus_release) |=> (grant == '0));

  assert_no_request_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> (grant == '0));

  assert_free_bus_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req != '0) |=> ((grant & $past(req)) != '0));

endmodule

bind bus_arbiter_desc bus_arbiter_desc_checks #(.N_MASTERS(N_MASTERS)) u_checks (.*);

// File: tb/bus_arbiter_desc_test.sv
module bus_arbiter_desc_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rr_mode = 1'b1;
  logic [N-1:0] req = '0;
  logic         bus_release = 1'b0;
  logic [N-1:0] grant;
  logic [1:0]   owner_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_busy = 0;
  int m_owner = 0;
  int m_ptr = N - 1;

  bus_arbiter_desc #(.N_MASTERS(N)) uut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req),
    .bus_release(bus_release), .grant(grant), .owner_idx(owner_idx)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] exp_g, input int exp_o);
    checks++;
    if (grant !== exp_g || int'(owner_idx) != exp_o) begin
      failures++;
      $display("FAIL %s grant=%b owner=%0d expected grant=%b owner=%0d",
               tag, grant, owner_idx, exp_g, exp_o);
    end
  endtask

  task automatic step(input logic pol, input logic [N-1:0] r, input logic rel);
    string tag;
    int w;
    rr_mode = pol; req = r; bus_release = rel;
    @(posedge clk);
    if (m_busy != 0) begin
      tag = rel ? "R8" : "R7";
      if (rel) m_busy = 0;
    end else if (r == '0) begin
      tag = rel ? "R10" : "R9";
    end else begin
      tag = pol ? "R4" : "R6";
      w = -1;
      if (pol) begin
        for (int k = 0; k < N; k++)
          if (w < 0 && r[(m_ptr + N - k) % N]) w = (m_ptr + N - k) % N;
      end else begin
        for (int i = 0; i < N; i++)
          if (w < 0 && r[i]) w = i;
      end
      m_busy = 1; m_owner = w;
      if (pol) m_ptr = (w == 0) ? N - 1 : w - 1;
    end
    @(negedge clk);
    check(tag, m_busy != 0 ? (N'(1) << m_owner) : '0, m_busy != 0 ? m_owner : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; bus_release = 1'b0;
    m_busy = 0; m_owner = 0; m_ptr = N - 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1", '0, 0);

    step(1, 4'b1010, 0);
    check("R3", 4'b1000, 3);
    step(1, 4'b1111, 1);
    step(1, 4'b1111, 0);
    check("R4", 4'b0100, 2);
    step(1, 4'b1111, 1);
    step(1, 4'b1011, 0);
    check("R4", 4'b0010, 1);

    do_reset();
    begin
      int exp_seq[5] = '{3, 2, 1, 0, 3};
      for (int g = 0; g < 5; g++) begin
        step(1, 4'b1111, 0);
        check(g == 4 ? "R5" : "R11", N'(1) << exp_seq[g], exp_seq[g]);
        step(1, 4'b1111, 1);
      end
    end

    do_reset();
    step(0, 4'b1110, 0);
    check("R6", 4'b0010, 1);
    step(0, 4'b1110, 1);
    step(1, 4'b1110, 0);
    check("R6", 4'b1000, 3);
    step(1, 4'b0000, 1);

    for (int pol = 0; pol < 2; pol++) begin
      do_reset();
      for (int pass = 0; pass < 3; pass++) begin
        for (int p = 0; p < 16; p++) begin
          step(pol[0], 4'(p), 1'b0);
          step(pol[0], 4'(p ^ 4'b1111), 1'b0);
          step(pol[0], 4'(p), 1'b1);
          step(pol[0], 4'b0000, 1'b1);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule